// File: doc/BRIEF.md
# Fixed-slope trapezoid edge sequencer

This block drives a 14-bit DAC with a trapezoidal wave whose zero crossings are timed to a fraction of a clock period. The output sits at the top or bottom rail between edges. Around each edge it plays a 16-sample ramp. Every ramp has the same slope, whatever the output frequency, so a single analog low-pass filter and comparator downstream recover edges with the same shape at every rate.

The user gives the spacing between crossings as a whole number of clock ticks plus a 10-bit fraction of a tick. After each edge, the block adds this spacing to a running edge time. The integer part of that time sets the clock tick at which the next ramp starts. The fraction picks one of 1024 ramps. Each of those ramps shifts the midscale crossing by a further 1/1024 of a tick. The ramp values are computed on the fly and are not stored.

Top module: `tzs_trapezoid_seq`

## Requirements
- R1: After reset, `dac_code` is 0 and `clamp_err` is 0.
- R2: While `en` is low, `dac_code` stays at code 0.
- R3: Call the rising edge that first samples `en` high edge 1. The first ramp is rising and uses fraction 0, and its sample i appears on `dac_code` after edge i+2.
- R4: Ramp sample i (i = 0..15) for fraction k is given as follows. The rising ramp has code r = clamp(1024*i - k, 0, 16383). The falling ramp has code 16383 - r. The code therefore passes midscale 8192 between samples 8 and 9, at k/1024 of that tick.
- R5: Between ramps the output holds 16383 after a rising ramp and 0 after a falling ramp. Rising and falling ramps alternate.
- R6: Take the edge times E0 = 0 and E(n+1) = E(n) + interval, counted in 1/1024 ticks. Ramp n starts floor(E(n)/1024) ticks after the first ramp and uses fraction E(n) mod 1024.
- R7: An interval whose integer part is below 16 is treated as exactly 16.0 ticks, with the fraction dropped. Latching such a value sets `clamp_err`.
- R8: Once set, `clamp_err` stays set until reset.
- R9: The interval is sampled only at the clock edge that ends a ramp (the edge that leaves sample 15). The value taken at the end of ramp n sets the spacing from E(n) to E(n+1). A change at any other time does not affect the gap in progress.
- R10: A spacing of exactly 16 ticks plays two ramps back to back, with no hold sample between them.
- R11: Dropping `en` forces `dac_code` to 0 by the second following edge. Raising `en` again restarts the sequence as in R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; when low the output is parked at the bottom rail |
| gap_ticks | input | 16 | Integer part of the spacing between crossings, in ticks |
| gap_frac | input | 10 | Fractional part of the spacing, in 1/1024 ticks |
| dac_code | output | 14 | Registered DAC code |
| clamp_err | output | 1 | Sticky flag: an interval below 16 ticks was clamped |

## Verification
Every output is due a fixed number of edges after its cause. Sample i of ramp n is due after edge floor(E(n)/1024)+i+2, counting from the edge that first sees `en`. An interval is used if it is present at the edge that ends the preceding ramp. `clamp_err` follows one edge after that latch, and a dropped `en` reaches the output after two edges. The bench samples `dac_code` on every falling edge and compares it with a model. The model builds edge times by absolute accumulation and works out, from that same latch edge, which interval each edge uses. Stimulus changes only on falling edges, so each change is counted against the correct latch edge.

// File: rtl/tzs_pkg.sv
package tzs_pkg;
  typedef enum logic [1:0] {
    SEG_IDLE = 2'd0,
    SEG_RAMP = 2'd1,
    SEG_HOLD = 2'd2
  } seg_e;
endpackage

// File: rtl/tzs_interval_latch.sv
// Clamps the requested spacing, adds it to the current edge fraction and
// holds the result taken at the end of each ramp.
module tzs_interval_latch #(
  parameter int TICK_W  = 16,
  parameter int FRAC_W  = 10,
  parameter int CNT_W   = 17,
  parameter int MIN_GAP = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TICK_W-1:0] ticks_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic [FRAC_W-1:0] cur_frac_i,
  input  logic              stb_i,
  output logic [CNT_W-1:0]  gap_now_o,
  output logic [FRAC_W-1:0] frac_now_o,
  output logic [CNT_W-1:0]  gap_q_o,
  output logic [FRAC_W-1:0] frac_q_o,
  output logic              err_o
);
  logic              too_small;
  logic [TICK_W-1:0] eff_ticks;
  logic [FRAC_W-1:0] eff_frac;
  logic [FRAC_W:0]   frac_sum;

  always_comb begin
    too_small  = ticks_i < TICK_W'(MIN_GAP);
    eff_ticks  = too_small ? TICK_W'(MIN_GAP) : ticks_i;
    eff_frac   = too_small ? '0 : frac_i;
    frac_sum   = {1'b0, cur_frac_i} + {1'b0, eff_frac};
    gap_now_o  = CNT_W'(eff_ticks) + CNT_W'(frac_sum[FRAC_W]);
    frac_now_o = frac_sum[FRAC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q_o  <= CNT_W'(MIN_GAP);
      frac_q_o <= '0;
      err_o    <= 1'b0;
    end else if (stb_i) begin
      gap_q_o  <= gap_now_o;
      frac_q_o <= frac_now_o;
      if (too_small) err_o <= 1'b1;
    end
  end

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);
  p_latch_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !stb_i |=> ($stable(gap_q_o) && $stable(frac_q_o)));
  p_gap_floor_r7: assert property (@(posedge clk) disable iff (rst)
    stb_i |=> (gap_q_o >= CNT_W'(MIN_GAP)));
endmodule

// File: rtl/tzs_edge_timer.sv
// Counts ticks from each ramp start and decides when the next ramp begins.
module tzs_edge_timer
  import tzs_pkg::*;
#(
  parameter int CNT_W    = 17,
  parameter int FRAC_W   = 10,
  parameter int RAMP_LEN = 16,
  parameter int IDX_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic [CNT_W-1:0]  gap_now_i,
  input  logic [FRAC_W-1:0] frac_now_i,
  input  logic [CNT_W-1:0]  gap_q_i,
  input  logic [FRAC_W-1:0] frac_q_i,
  output logic              stb_o,
  output seg_e              seg_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic              rise_o
);
  seg_e              seg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [FRAC_W-1:0] frac_q;
  logic              rise_q;
  logic              ramp_end;
  logic              restart;

  always_comb begin
    ramp_end = (seg_q == SEG_RAMP) && (cnt_q == CNT_W'(RAMP_LEN - 1));
    restart  = (ramp_end && (gap_now_i == CNT_W'(RAMP_LEN))) ||
               ((seg_q == SEG_HOLD) && (cnt_q == gap_q_i - CNT_W'(1)));
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      seg_q  <= SEG_IDLE;
      cnt_q  <= '0;
      frac_q <= '0;
      rise_q <= 1'b0;
    end else begin
      case (seg_q)
        SEG_IDLE: begin
          seg_q  <= SEG_RAMP;
          cnt_q  <= '0;
          frac_q <= '0;
          rise_q <= 1'b1;
        end
        default: begin
          if (restart) begin
            seg_q  <= SEG_RAMP;
            cnt_q  <= '0;
            rise_q <= ~rise_q;
            frac_q <= ramp_end ? frac_now_i : frac_q_i;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (ramp_end) seg_q <= SEG_HOLD;
          end
        end
      endcase
    end
  end

  assign stb_o  = ramp_end;
  assign seg_o  = seg_q;
  assign idx_o  = cnt_q[IDX_W-1:0];
  assign frac_o = frac_q;
  assign rise_o = rise_q;

  p_hold_after_ramp_r10: assert property (@(posedge clk) disable iff (rst)
    (seg_q == SEG_HOLD) |-> (cnt_q >= CNT_W'(RAMP_LEN)));
endmodule

// File: rtl/tzs_code_gen.sv
// Turns segment, sample index and fraction into a registered DAC code.
module tzs_code_gen
  import tzs_pkg::*;
#(
  parameter int DAC_W  = 14,
  parameter int FRAC_W = 10,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  seg_e              seg_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              rise_i,
  output logic [DAC_W-1:0]  dac_o
);
  localparam int              SHIFT    = DAC_W - IDX_W;
  localparam logic [DAC_W-1:0] CODE_MAX = '1;
  localparam longint          MAX_L    = (64'sd1 <<< DAC_W) - 1;

  function automatic logic [DAC_W-1:0] ramp_code(
    input logic [IDX_W-1:0]  i,
    input logic [FRAC_W-1:0] k,
    input logic              up
  );
    longint            diff;
    logic [DAC_W-1:0]  mag;
    diff = (longint'(i) <<< FRAC_W) - longint'(k);
    if (diff <= 0) begin
      mag = '0;
    end else begin
      diff = (diff <<< SHIFT) >>> FRAC_W;
      mag  = (diff > MAX_L) ? CODE_MAX : DAC_W'(diff);
    end
    return up ? mag : ~mag;
  endfunction

  seg_e seg_q;
  logic rise_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_o  <= '0;
      seg_q  <= SEG_IDLE;
      rise_q <= 1'b0;
    end else begin
      seg_q  <= seg_i;
      rise_q <= rise_i;
      case (seg_i)
        SEG_RAMP: dac_o <= ramp_code(idx_i, frac_i, rise_i);
        SEG_HOLD: dac_o <= rise_i ? CODE_MAX : '0;
        default:  dac_o <= '0;
      endcase
    end
  end

  p_rise_monotone_r4: assert property (@(posedge clk) disable iff (rst)
    (seg_q == SEG_RAMP && $past(seg_q) == SEG_RAMP && rise_q && $past(rise_q))
      |-> (dac_o >= $past(dac_o)));
  p_fall_monotone_r4: assert property (@(posedge clk) disable iff (rst)
    (seg_q == SEG_RAMP && $past(seg_q) == SEG_RAMP && !rise_q && !$past(rise_q))
      |-> (dac_o <= $past(dac_o)));
  p_hold_steady_r5: assert property (@(posedge clk) disable iff (rst)
    (seg_q == SEG_HOLD && $past(seg_q) == SEG_HOLD) |-> $stable(dac_o));
endmodule

// File: rtl/tzs_trapezoid_seq.sv
module tzs_trapezoid_seq #(
  parameter int DAC_W    = 14,
  parameter int FRAC_W   = 10,
  parameter int TICK_W   = 16,
  parameter int RAMP_LEN = 16,
  parameter int MIN_GAP  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [TICK_W-1:0] gap_ticks,
  input  logic [FRAC_W-1:0] gap_frac,
  output logic [DAC_W-1:0]  dac_code,
  output logic              clamp_err
);
  import tzs_pkg::*;

  localparam int IDX_W = $clog2(RAMP_LEN);
  localparam int CNT_W = TICK_W + 1;

  logic              stb;
  logic [CNT_W-1:0]  gap_now;
  logic [FRAC_W-1:0] frac_now;
  logic [CNT_W-1:0]  gap_q;
  logic [FRAC_W-1:0] frac_q;
  seg_e              seg;
  logic [IDX_W-1:0]  idx;
  logic [FRAC_W-1:0] frac_cur;
  logic              rise;

  tzs_interval_latch #(
    .TICK_W(TICK_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W), .MIN_GAP(MIN_GAP)
  ) u_latch (
    .clk(clk), .rst(rst), .ticks_i(gap_ticks), .frac_i(gap_frac),
    .cur_frac_i(frac_cur), .stb_i(stb), .gap_now_o(gap_now),
    .frac_now_o(frac_now), .gap_q_o(gap_q), .frac_q_o(frac_q),
    .err_o(clamp_err)
  );

  tzs_edge_timer #(
    .CNT_W(CNT_W), .FRAC_W(FRAC_W), .RAMP_LEN(RAMP_LEN), .IDX_W(IDX_W)
  ) u_timer (
    .clk(clk), .rst(rst), .en_i(en), .gap_now_i(gap_now),
    .frac_now_i(frac_now), .gap_q_i(gap_q), .frac_q_i(frac_q),
    .stb_o(stb), .seg_o(seg), .idx_o(idx), .frac_o(frac_cur), .rise_o(rise)
  );

  tzs_code_gen #(
    .DAC_W(DAC_W), .FRAC_W(FRAC_W), .IDX_W(IDX_W)
  ) u_code (
    .clk(clk), .rst(rst), .seg_i(seg), .idx_i(idx), .frac_i(frac_cur),
    .rise_i(rise), .dac_o(dac_code)
  );
endmodule

// File: tb/tzs_trapezoid_seq_bench.sv
`timescale 1ns/1ps
module tzs_trapezoid_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [15:0] gap_ticks = 16'd20;
  logic [9:0]  gap_frac = 10'd0;
  logic [13:0] dac_code;
  logic        clamp_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tzs_trapezoid_seq u_tzs_trapezoid_seq (
    .clk(clk), .rst(rst), .en(en), .gap_ticks(gap_ticks),
    .gap_frac(gap_frac), .dac_code(dac_code), .clamp_err(clamp_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint step_of(input int ti, input int fr);
    if (ti < 16) return 64'd16 * 1024;   // R7 clamp to 16.0
    return longint'(ti) * 1024 + fr;
  endfunction

  // Expected code for capture j: edge times accumulate in 1/1024 ticks (R6);
  // the interval for E(n)->E(n+1) is the one present at the end of ramp n (R9).
  function automatic int exp_code(input int j, input int i0, input int f0,
                                  input int chg, input int i1, input int f1);
    longint e = 0;
    int t, st, ls, lf, ln, n, idx, r;
    if (j == 0) return 0;
    t = j - 1; ls = 0; lf = 0; ln = 0; n = 0;
    while (1) begin
      st = int'(e >>> 10);
      if (st > t) break;
      ls = st; lf = int'(e % 1024); ln = n;
      e = e + ((chg <= st + 15) ? step_of(i1, f1) : step_of(i0, f0));
      n++;
    end
    idx = t - ls;
    if (idx < 16) begin
      r = 1024 * idx - lf;
      if (r < 0) r = 0;
      if (r > 16383) r = 16383;
      return (ln % 2 == 0) ? r : 16383 - r;
    end
    return (ln % 2 == 0) ? 16383 : 0;
  endfunction

  // Restart from idle and compare every cycle against the model.
  task automatic run_stream(input string tag, input int i0, input int f0,
                            input int chg, input int i1, input int f1,
                            input int ncyc);
    @(negedge clk);
    en = 1'b0;
    repeat (3) @(negedge clk);
    gap_ticks = 16'(i0);
    gap_frac  = 10'(f0);
    en = 1'b1;
    for (int j = 0; j < ncyc; j++) begin
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("%s cyc %0d", tag, j), int'(dac_code),
          exp_code(j, i0, f0, chg, i1, f1));
      if (j == chg) begin
        gap_ticks = 16'(i1);
        gap_frac  = 10'(f1);
      end
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset dac", int'(dac_code), 0);
    chk("R1 reset err", int'(clamp_err), 0);
  endtask

  task automatic t_idle;
    gap_ticks = 16'd20;
    en = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R2 idle low", int'(dac_code), 0);
    end
  endtask

  task automatic t_integer;
    run_stream("R3/R4/R5/R6 int 20", 20, 0, 1 << 30, 20, 0, 100);
    chk("R7 no flag at 20", int'(clamp_err), 0);
  endtask

  task automatic t_fraction;
    run_stream("R4/R6 frac 20+300", 20, 300, 1 << 30, 20, 300, 130);
  endtask

  task automatic t_min_gap;
    run_stream("R10 gap 16+1000", 16, 1000, 1 << 30, 16, 1000, 130);
    chk("R7 no flag at 16", int'(clamp_err), 0);
  endtask

  task automatic t_latch;
    // change lands in the hold after ramp 0: must not alter the gap to ramp 1
    run_stream("R9 deferred change", 24, 0, 20, 40, 512, 150);
  endtask

  task automatic t_disable;
    @(negedge clk);
    en = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R11 low after disable", int'(dac_code), 0);
    repeat (3) @(negedge clk);
    chk("R11 stays low", int'(dac_code), 0);
  endtask

  task automatic t_clamp;
    run_stream("R7 clamp 5+700", 5, 700, 1 << 30, 5, 700, 80);
    chk("R7 flag set", int'(clamp_err), 1);
  endtask

  task automatic t_sticky;
    run_stream("R8 valid after clamp", 20, 0, 1 << 30, 20, 0, 60);
    chk("R8 flag sticky", int'(clamp_err), 1);
    t_reset();
    chk("R8 flag cleared by reset", int'(clamp_err), 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R3 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle();
    t_integer();
    t_disable();
    t_fraction();
    t_min_gap();
    t_latch();
    t_disable();
    t_clamp();
    t_sticky();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule